// File: doc/BRIEF.md
# Resistive Sensor Array Scan Controller

This block sequences measurements across a two-dimensional array of self-resetting sensor pixels. For each pixel it first charges the row with a single-cycle charge strobe. It then holds a read strobe on that row and counts clock cycles for as long as the chosen column's output stays high. The count saturates at full scale if the pulse never ends. Every column output enters the block, and an internal selector picks the column under measurement.

Each finished measurement leaves the block as a serial frame on one output pin. The frame holds a start bit, the row index, the column index and the count. A serial command on one input pin sets the rectangular region to scan and picks between single-pass and continuous scanning. Only clock, reset, the command pin and the result pin connect to the outside. The serial pins run at the clock rate and have no back-pressure: a frame, once begun, is sent without pause, and a command that arrives while a scan is running is discarded rather than stalled.

Top module: `scan_array_ctrl`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the following idle state, every charge strobe, every read strobe and the serial output are low.
- R2: A pixel measurement begins with exactly one charge strobe, the one for the pixel's row, held high for exactly one clock cycle. At most one charge strobe is ever high.
- R3: In the cycle after the charge, the charge strobe is low and the read strobe of the same row is high. The read strobe stays high, and no other read strobe rises, until the measurement ends.
- R4: The count equals the number of read cycles during which the selected column's output (chosen by the column index) is high, counted from the first read cycle. A pixel whose output is already low in the first read cycle gives a count of 0.
- R5: The count saturates at 2^CNT_W-1. When it is reached while the output is still high, the measurement ends with that value.
- R6: Each result frame is a 1 start bit, then the 8-bit row index, the 5-bit column index and the CNT_W-bit count, each MSB first, one bit per clock. The line is low whenever no frame is being sent.
- R7: Pixels are measured row by row from the region's first row and first column, with the column advancing fastest.
- R8: Each charge strobe is preceded by a cycle with all strobes low and the serial output low.
- R9: A command is a 1 start bit followed by 32 bits, MSB first: bits 31:24 first row, 23:16 last row, 15:11 first column, 10:6 last column, bit 5 continuous mode, bits 4:0 unused. Bounds are inclusive.
- R10: A command that completes while a scan is in progress has no effect.
- R11: A command whose first row exceeds its last row, whose first column exceeds its last column, or whose last row or last column lies outside the array is discarded, and the block stays idle.
- R12: In continuous mode the region is rescanned from its first pixel after its last pixel, with no limit until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Serial command input |
| data_out | output | 1 | Serial result frame output |
| row_en | output | ROWS (234) | One-hot row charge strobes |
| row_rd | output | ROWS (234) | One-hot row read strobes |
| pix_out | input | COLS (23) | Pixel outputs, one per column |

## Verification
The assertions assume that a pixel output goes high only after its row has been charged, and that it can be high only while that row's read strobe is on. They also assume that a command reaches the input as one unbroken burst of start bit and 32 data bits, with the line low in between. The bench pixel model gates every column output with the read strobe of the last charged row and gives each pixel a distinct programmable pulse length. Among these pulse lengths are an immediately low pixel and one long enough to saturate the counter. Commands are sent only as whole bursts: a valid region, a region sent during a running scan, inverted and out-of-array regions, and a continuous region that is ended by reset.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_CHARGE = 3'd1,
    SQ_READ   = 3'd2,
    SQ_SEND   = 3'd3,
    SQ_GAP    = 3'd4
  } seq_state_t;
endpackage

// File: rtl/scan_cmd_rx.sv
module scan_cmd_rx #(
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  output logic             word_valid,
  output logic [CMD_W-1:0] word
);
  localparam int BW = $clog2(CMD_W + 1);

  logic             busy;
  logic [BW-1:0]    nbits;
  logic [CMD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      nbits      <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!busy) begin
        if (ser_in) begin
          busy  <= 1'b1;
          nbits <= '0;
        end
      end else begin
        shreg <= {shreg[CMD_W-2:0], ser_in};
        if (nbits == BW'(CMD_W - 1)) begin
          busy       <= 1'b0;
          word_valid <= 1'b1;
          word       <= {shreg[CMD_W-2:0], ser_in};
        end else begin
          nbits <= nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int ROWS  = 234,
  parameter int COLS  = 23,
  parameter int ROW_W = 8,
  parameter int COL_W = 5,
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             meas_done,
  input  logic             tx_last,
  output seq_state_t       state,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col
);
  localparam int SR_LO   = CMD_W - ROW_W;
  localparam int ER_LO   = SR_LO - ROW_W;
  localparam int SC_LO   = ER_LO - COL_W;
  localparam int EC_LO   = SC_LO - COL_W;
  localparam int CONT_IX = EC_LO - 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [ROW_W-1:0] f_srow, f_erow, r_lo, r_hi;
  logic [COL_W-1:0] f_scol, f_ecol, c_lo, c_hi;
  logic             f_cont, cont;
  logic             region_ok;
  logic             at_last_col, at_last_row;

  assign f_srow = cmd_word[CMD_W-1:SR_LO];
  assign f_erow = cmd_word[SR_LO-1:ER_LO];
  assign f_scol = cmd_word[ER_LO-1:SC_LO];
  assign f_ecol = cmd_word[SC_LO-1:EC_LO];
  assign f_cont = cmd_word[CONT_IX];

  assign region_ok = (f_srow <= f_erow) && (f_erow <= LAST_ROW) &&
                     (f_scol <= f_ecol) && (f_ecol <= LAST_COL);

  assign at_last_col = (cur_col == c_hi);
  assign at_last_row = (cur_row == r_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cur_row <= '0;
      cur_col <= '0;
      r_lo    <= '0;
      r_hi    <= '0;
      c_lo    <= '0;
      c_hi    <= '0;
      cont    <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (cmd_valid && region_ok) begin
            r_lo    <= f_srow;
            r_hi    <= f_erow;
            c_lo    <= f_scol;
            c_hi    <= f_ecol;
            cont    <= f_cont;
            cur_row <= f_srow;
            cur_col <= f_scol;
            state   <= SQ_CHARGE;
          end
        end
        SQ_CHARGE: state <= SQ_READ;
        SQ_READ: begin
          if (meas_done) state <= SQ_SEND;
        end
        SQ_SEND: begin
          if (tx_last) state <= SQ_GAP;
        end
        SQ_GAP: begin
          if (!at_last_col) begin
            cur_col <= cur_col + 1'b1;
            state   <= SQ_CHARGE;
          end else if (!at_last_row) begin
            cur_col <= c_lo;
            cur_row <= cur_row + 1'b1;
            state   <= SQ_CHARGE;
          end else if (cont) begin
            cur_col <= c_lo;
            cur_row <= r_lo;
            state   <= SQ_CHARGE;
          end else begin
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_pulse_counter.sv
module scan_pulse_counter #(
  parameter int COLS  = 23,
  parameter int COL_W = 5,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             active,
  input  logic [COLS-1:0]  pix_out,
  input  logic [COL_W-1:0] col_sel,
  output logic             pix_sel,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [COLS-1:0] col_hit;

  for (genvar g = 0; g < COLS; g++) begin : g_colsel
    assign col_hit[g] = (col_sel == COL_W'(g)) && pix_out[g];
  end

  assign pix_sel = |col_hit;
  assign done    = active && (!pix_sel || (count == CNT_MAX));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (active && pix_sel && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/scan_frame_tx.sv
module scan_frame_tx #(
  parameter int FRAME_W = 34
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               ser_out,
  output logic               last
);
  localparam int LW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [LW-1:0]      left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= frame;
      left  <= LW'(FRAME_W);
    end else if (left != '0) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  assign ser_out = (left != '0) && shreg[FRAME_W-1];
  assign last    = (left == LW'(1));
endmodule

// File: rtl/scan_array_ctrl.sv
module scan_array_ctrl
  import scan_pkg::*;
#(
  parameter int ROWS  = 234,
  parameter int COLS  = 23,
  parameter int ROW_W = 8,
  parameter int COL_W = 5,
  parameter int CNT_W = 20,
  parameter int CMD_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_in,
  output logic            data_out,
  output logic [ROWS-1:0] row_en,
  output logic [ROWS-1:0] row_rd,
  input  logic [COLS-1:0] pix_out
);
  localparam int FRAME_W = 1 + ROW_W + COL_W + CNT_W;

  logic             cmd_valid;
  logic [CMD_W-1:0] cmd_word;
  seq_state_t       state;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             meas_done;
  logic             tx_last;
  logic             pix_sel;
  logic [CNT_W-1:0] cnt_val;
  logic             in_charge, in_read;

  scan_cmd_rx #(.CMD_W(CMD_W)) u_rx (
    .clk(clk), .rst(rst), .ser_in(cmd_in),
    .word_valid(cmd_valid), .word(cmd_word)
  );

  scan_sequencer #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .CMD_W(CMD_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .meas_done(meas_done), .tx_last(tx_last),
    .state(state), .cur_row(cur_row), .cur_col(cur_col)
  );

  assign in_charge = (state == SQ_CHARGE);
  assign in_read   = (state == SQ_READ);

  scan_pulse_counter #(.COLS(COLS), .COL_W(COL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(in_charge), .active(in_read),
    .pix_out(pix_out), .col_sel(cur_col),
    .pix_sel(pix_sel), .count(cnt_val), .done(meas_done)
  );

  scan_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .load(meas_done),
    .frame({1'b1, cur_row, cur_col, cnt_val}),
    .ser_out(data_out), .last(tx_last)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_rowdec
    assign row_en[g] = in_charge && (cur_row == ROW_W'(g));
    assign row_rd[g] = in_read   && (cur_row == ROW_W'(g));
  end
endmodule

// File: rtl/scan_array_ctrl_chk.sv
module scan_array_ctrl_chk #(
  parameter int ROWS  = 234,
  parameter int CNT_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_en,
  input logic [ROWS-1:0] row_rd,
  input logic            data_out,
  input logic [CNT_W-1:0] cnt,
  input logic            pix_sel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en)); // R2
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_rd)); // R3
  AST_CHARGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|row_en) |=> (row_en == '0)); // R2
  AST_READ_FOLLOWS_CHARGE: assert property (@(posedge clk) disable iff (rst)
    (|row_en) |=> (row_rd == $past(row_en))); // R3
  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    ((|row_rd) && pix_sel && (cnt != CNT_MAX)) |=> (row_rd == $past(row_rd))); // R3
  AST_SAT_ENDS: assert property (@(posedge clk) disable iff (rst)
    ((|row_rd) && (cnt == CNT_MAX)) |=> (row_rd == '0)); // R5
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((|row_rd) || (|row_en)) |-> !data_out); // R6
  AST_GAP_BEFORE_CHARGE: assert property (@(posedge clk) disable iff (rst)
    (|row_en) |-> $past((row_en == '0) && (row_rd == '0) && !data_out)); // R8
endmodule

bind scan_array_ctrl scan_array_ctrl_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .row_en(row_en), .row_rd(row_rd),
  .data_out(data_out), .cnt(cnt_val), .pix_sel(pix_sel)
);

// File: tb/tb_scan_array_ctrl.sv
module tb_scan_array_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 12;
  localparam int COLS  = 5;
  localparam int ROW_W = 8;
  localparam int COL_W = 5;
  localparam int CNT_W = 8;
  localparam int CMD_W = 32;
  localparam int PAY_W = ROW_W + COL_W + CNT_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_in = 1'b0;
  logic            data_out;
  logic [ROWS-1:0] row_en, row_rd;
  logic [COLS-1:0] pix_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [PAY_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_array_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W),
    .CNT_W(CNT_W), .CMD_W(CMD_W)
  ) dut (
    .clk(clk), .rst(rst), .cmd_in(cmd_in), .data_out(data_out),
    .row_en(row_en), .row_rd(row_rd), .pix_out(pix_out)
  );

  function automatic int pix_delay(int r, int c);
    if (r == 5 && c == 1) return 1000;
    if (r == 2 && c == 3) return 0;
    return ((r * 7 + c * 13) % 40) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // pixel model: output high while its row is read and its pulse lasts
  int rem [COLS];
  int act_row = 0;
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < COLS; c++) rem[c] <= 0;
    end else if (|row_en) begin
      for (int r = 0; r < ROWS; r++)
        if (row_en[r]) begin
          act_row <= r;
          for (int c = 0; c < COLS; c++) rem[c] <= pix_delay(r, c);
        end
    end else if (row_rd[act_row]) begin
      for (int c = 0; c < COLS; c++) if (rem[c] > 0) rem[c] <= rem[c] - 1;
    end
  end
  always_comb begin
    for (int c = 0; c < COLS; c++) pix_out[c] = row_rd[act_row] && (rem[c] > 0);
  end

  // per-clock reference comparison: strobes and serial frames
  logic [ROWS-1:0] prev_en = '0, prev_rd = '0;
  logic            prev_do = 1'b0;
  bit              in_frame = 0;
  int              nbit = 0;
  logic [PAY_W-1:0] acc;
  always @(negedge clk) begin
    if (!rst) begin
      if (|prev_en) begin
        chk(row_en == '0, "R2", "charge strobe after one cycle", longint'(row_en), 0);
        chk(row_rd == prev_en, "R3", "read row after charge", longint'(row_rd), longint'(prev_en));
      end
      if (|row_en && !(|prev_en)) begin
        chk($onehot(row_en), "R2", "charge one-hot", longint'($countones(row_en)), 1);
        chk(prev_rd == '0 && !prev_do, "R8", "quiet cycle before charge",
            longint'($countones(prev_rd)) + longint'(prev_do), 0);
      end
      if (!in_frame) begin
        if (data_out) begin in_frame = 1; nbit = 0; end
      end else begin
        acc = {acc[PAY_W-2:0], data_out};
        nbit++;
        if (nbit == PAY_W) begin
          in_frame = 0;
          if (exp_q.size() == 0) begin
            chk(0, "R10", "unexpected frame (R11/R12 also)", longint'(acc), -1);
          end else begin
            logic [PAY_W-1:0] e;
            e = exp_q.pop_front();
            chk(acc[PAY_W-1:CNT_W] == e[PAY_W-1:CNT_W], "R7", "frame address",
                longint'(acc[PAY_W-1:CNT_W]), longint'(e[PAY_W-1:CNT_W]));
            chk(acc[CNT_W-1:0] == e[CNT_W-1:0],
                (e[CNT_W-1:0] == CNT_W'(CNT_MAX)) ? "R5" : "R4", "frame count (R6 layout)",
                longint'(acc[CNT_W-1:0]), longint'(e[CNT_W-1:0]));
          end
        end
      end
    end else begin
      in_frame = 0;
    end
    prev_en <= row_en;
    prev_rd <= row_rd;
    prev_do <= data_out;
  end

  task automatic send_cmd(int sr, int er, int sc, int ec, bit cont);
    logic [CMD_W-1:0] w;
    w = {ROW_W'(sr), ROW_W'(er), COL_W'(sc), COL_W'(ec), cont, 5'd0}; // R9 layout
    @(negedge clk) cmd_in = 1'b1;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      @(negedge clk) cmd_in = w[i];
    end
    @(negedge clk) cmd_in = 1'b0;
  endtask

  task automatic expect_region(int sr, int er, int sc, int ec, int passes);
    for (int p = 0; p < passes; p++)
      for (int r = sr; r <= er; r++)
        for (int c = sc; c <= ec; c++) begin
          int d;
          d = pix_delay(r, c);
          if (d > CNT_MAX) d = CNT_MAX;
          exp_q.push_back({ROW_W'(r), COL_W'(c), CNT_W'(d)});
        end
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_quiet(int ncyc, string req);
    bit busy_seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (row_en != '0 || row_rd != '0 || data_out) busy_seen = 1;
    end
    chk(!busy_seen, req, "block stays idle", longint'(busy_seen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(row_en == '0 && row_rd == '0 && !data_out, "R1", "outputs in reset",
        longint'(row_en | row_rd) + longint'(data_out), 0);
    rst = 1'b0;
    check_quiet(20, "R1");

    // single pixel whose output is low from the first read cycle (R4, R9)
    expect_region(2, 2, 3, 3, 1);
    send_cmd(2, 2, 3, 3, 1'b0);
    wait_drain();

    // full scan of the array, including a saturating pixel (R5, R7)
    expect_region(0, ROWS - 1, 0, COLS - 1, 1);
    send_cmd(0, ROWS - 1, 0, COLS - 1, 1'b0);
    repeat (150) @(negedge clk);
    send_cmd(0, 0, 0, 0, 1'b0); // arrives while busy: must be ignored (R10)
    wait_drain();
    check_quiet(300, "R10");

    // rejected regions (R11)
    send_cmd(4, 2, 0, 1, 1'b0);
    check_quiet(60, "R11");
    send_cmd(0, 1, 1, 7, 1'b0);
    check_quiet(60, "R11");
    send_cmd(0, ROWS, 0, 0, 1'b0);
    check_quiet(60, "R11");

    // continuous region, three passes, then reset (R12, R1)
    expect_region(1, 2, 3, 4, 3);
    send_cmd(1, 2, 3, 4, 1'b1);
    while (exp_q.size() != 0) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(row_en == '0 && row_rd == '0 && !data_out, "R1", "outputs after mid-scan reset",
        longint'(row_en | row_rd) + longint'(data_out), 0);
    rst = 1'b0;
    check_quiet(200, "R12");

    finish_run();
  end
endmodule